// File: doc/BRIEF.md
# Serial-Bus PHY Power-State Manager

This block decides the power state of a serial-bus physical-layer device and of its interface to the link-layer controller. It watches the link power status input, the port status flags and the port event pulses. From these it puts the device into one of two sleep depths, wakes it up again, and drives the clock-generator and reference-circuit enables. It also drives a one-cycle interface-initialize strobe and a flag that says the system clock toward the link is valid.

The block leaves normal operation when the link power status drops. Sleep is entered only while the interface is disabled and the port is idle, meaning disconnected, disabled or suspended. The sleep depth follows the port state and the port interrupt enable bit.

A wake-up starts when link power status returns or when a port event needs a response. The clock generators then run for a fixed number of ticks of an always-on slow clock before the system clock is declared valid. The tick count is set by a parameter and sized to fit the 7.3 ms bound.

Top module: `phy_pwr_mgr`

## Requirements
- R1: While rst_n is low and on the first cycle after reset, pm_state is 1 (interface disabled), clk_gen_en, ref_det_en, ref_conn_en, ref_full_en and sysclk_valid are 1, and if_init is 0.
- R2: In state 1 with lps high, the next cycle has pm_state 0 (normal). In state 0 with lps low, the next cycle has pm_state 1.
- R3: Sleep is entered from state 1 only, and only when lps is low and at least one of port_disc, port_dis or port_susp is high. With all three low, or in state 0, the block never sleeps.
- R4: Deep sleep (pm_state 3) is chosen when port_disc is high, or when port_dis is high and port_int_en is low. Otherwise light sleep (pm_state 2) is chosen. The choice is re-evaluated on every sleeping cycle that has no wake cause.
- R5: In state 2, clk_gen_en, ref_full_en and sysclk_valid are 0 while ref_det_en and ref_conn_en are 1. In state 3, only ref_conn_en is 1.
- R6: In state 2 or 3, lps high moves the block to waking (pm_state 4) on the next cycle. In state 4, all enables are 1 and sysclk_valid is 0.
- R7: A sleeping block also wakes on ev_bias or ev_disconnect while port_susp is high, or on ev_connect while port_dis is low. Any other event leaves the state and the enables unchanged.
- R8: State 4 lasts exactly WAKE_TICKS cycles with slow_tick high. On the last one, the block moves to state 0 if lps is high and to state 1 otherwise, and sysclk_valid becomes 1.
- R9: if_init is high for exactly one cycle, on the first cycle in state 0 after a state other than 0. It is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| slow_tick | input | 1 | One-cycle pulse from the always-on slow timebase |
| lps | input | 1 | Link power status, high when the link is powered |
| port_disc | input | 1 | Port is disconnected |
| port_dis | input | 1 | Port is disabled |
| port_susp | input | 1 | Port is suspended |
| port_int_en | input | 1 | Port interrupt enable |
| ev_bias | input | 1 | Pulse: incoming bias detected |
| ev_disconnect | input | 1 | Pulse: disconnection detected |
| ev_connect | input | 1 | Pulse: new connection detected |
| clk_gen_en | output | 1 | Enable for the internal clock generators |
| ref_det_en | output | 1 | Enable for the bias and disconnect detection references |
| ref_conn_en | output | 1 | Enable for the connection detection reference |
| ref_full_en | output | 1 | Enable for the remaining reference circuits |
| if_init | output | 1 | One-cycle strobe that initializes the link interface |
| sysclk_valid | output | 1 | System clock toward the link is valid |
| pm_state | output | 3 | Current state: 0 normal, 1 interface disabled, 2 light sleep, 3 deep sleep, 4 waking |

## Verification
The bench builds the block with WAKE_TICKS set to 5 and drives slow_tick itself as single pulses. This lets it count the waking window tick by tick and check the state both one tick before and exactly at the end. With the default value the window would span hundreds of slow ticks. The short window also makes room for wake-ups from both sleep depths, for every qualifying port event, and for the ignored events in the same short run.

// File: rtl/phy_pwr_mgr.sv
module phy_pwr_mgr #(
  parameter int WAKE_TICKS = 230
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       lps,
  input  logic       port_disc,
  input  logic       port_dis,
  input  logic       port_susp,
  input  logic       port_int_en,
  input  logic       ev_bias,
  input  logic       ev_disconnect,
  input  logic       ev_connect,
  output logic       clk_gen_en,
  output logic       ref_det_en,
  output logic       ref_conn_en,
  output logic       ref_full_en,
  output logic       if_init,
  output logic       sysclk_valid,
  output logic [2:0] pm_state
);
  localparam int CW = $clog2(WAKE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_TICKS - 1);

  typedef enum logic [2:0] {
    S_NORMAL = 3'd0,
    S_IFDIS  = 3'd1,
    S_LIGHT  = 3'd2,
    S_DEEP   = 3'd3,
    S_WAKE   = 3'd4
  } pm_t;

  pm_t st, nx;
  logic [CW-1:0] cnt;

  logic idle, deep, wake_evt, asleep, wake_done;
  assign idle      = port_disc | port_dis | port_susp;
  assign deep      = port_disc | (port_dis & ~port_int_en);
  assign wake_evt  = ((ev_bias | ev_disconnect) & port_susp) | (ev_connect & ~port_dis);
  assign asleep    = (st == S_LIGHT) || (st == S_DEEP);
  assign wake_done = (st == S_WAKE) && slow_tick && (cnt == LAST);

  always_comb begin
    nx = st;
    unique case (st)
      S_NORMAL: if (!lps) nx = S_IFDIS;
      S_IFDIS: begin
        if (lps)       nx = S_NORMAL;
        else if (idle) nx = deep ? S_DEEP : S_LIGHT;
      end
      S_LIGHT, S_DEEP: begin
        if (lps || wake_evt) nx = S_WAKE;
        else                 nx = deep ? S_DEEP : S_LIGHT;
      end
      S_WAKE: if (wake_done) nx = lps ? S_NORMAL : S_IFDIS;
      default: nx = S_IFDIS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IFDIS;
      cnt     <= '0;
      if_init <= 1'b0;
    end else begin
      st      <= nx;
      if_init <= (nx == S_NORMAL) && (st != S_NORMAL);
      if (st != S_WAKE)  cnt <= '0;
      else if (slow_tick) cnt <= cnt + 1'b1;
    end
  end

  assign pm_state     = st;
  assign clk_gen_en   = !asleep;
  assign ref_conn_en  = 1'b1;
  assign ref_det_en   = st != S_DEEP;
  assign ref_full_en  = !asleep;
  assign sysclk_valid = (st == S_NORMAL) || (st == S_IFDIS);
endmodule

// File: rtl/phy_pwr_mgr_chk.sv
module phy_pwr_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lps,
  input logic       port_disc,
  input logic       port_dis,
  input logic       port_susp,
  input logic       ev_connect,
  input logic       clk_gen_en,
  input logic       if_init,
  input logic       sysclk_valid,
  input logic [2:0] pm_state
);
  logic sleeping;
  assign sleeping = (pm_state == 3'd2) || (pm_state == 3'd3);

  a_r2_normal_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd0 && !lps) |=> pm_state == 3'd1);

  a_r3_no_sleep_active: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd1 && !(port_disc | port_dis | port_susp)) |=> !sleeping);

  a_r3_no_sleep_from_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd0) |=> !sleeping);

  a_r5_sleep_clocks_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> (!clk_gen_en && !sysclk_valid));

  a_r6_lps_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && lps) |=> pm_state == 3'd4);

  a_r7_connect_on_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd3 && !lps && ev_connect && port_dis && !port_susp) |=> pm_state != 3'd4);

  a_r8_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd4) |=> (pm_state == 3'd4 || pm_state == 3'd0 || pm_state == 3'd1));

  a_r9_init_single: assert property (@(posedge clk) disable iff (!rst_n)
    if_init |=> !if_init);

  a_r9_init_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
    if_init |-> pm_state == 3'd0);
endmodule

bind phy_pwr_mgr phy_pwr_mgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lps(lps), .port_disc(port_disc), .port_dis(port_dis),
  .port_susp(port_susp), .ev_connect(ev_connect), .clk_gen_en(clk_gen_en),
  .if_init(if_init), .sysclk_valid(sysclk_valid), .pm_state(pm_state)
);

// File: tb/phy_pwr_mgr_bench.sv
module phy_pwr_mgr_bench;
  localparam int NT = 5;
  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, lps = 1'b0;
  logic port_disc = 1'b0, port_dis = 1'b0, port_susp = 1'b0, port_int_en = 1'b0;
  logic ev_bias = 1'b0, ev_disconnect = 1'b0, ev_connect = 1'b0;
  logic clk_gen_en, ref_det_en, ref_conn_en, ref_full_en, if_init, sysclk_valid;
  logic [2:0] pm_state;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  phy_pwr_mgr #(.WAKE_TICKS(NT)) u_phy_pwr_mgr (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .lps(lps),
    .port_disc(port_disc), .port_dis(port_dis), .port_susp(port_susp),
    .port_int_en(port_int_en), .ev_bias(ev_bias), .ev_disconnect(ev_disconnect),
    .ev_connect(ev_connect), .clk_gen_en(clk_gen_en), .ref_det_en(ref_det_en),
    .ref_conn_en(ref_conn_en), .ref_full_en(ref_full_en), .if_init(if_init),
    .sysclk_valid(sysclk_valid), .pm_state(pm_state)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input int st, input int en);
    chk(req, "pm_state", int'(pm_state), st);
    chk(req, "enables{clk,det,conn,full,valid}",
        int'({clk_gen_en, ref_det_en, ref_conn_en, ref_full_en, sysclk_valid}), en);
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask
  task automatic tick(); slow_tick = 1'b1; step(); slow_tick = 1'b0; endtask

  task automatic pulse(input int which);
    ev_bias = (which == 0); ev_disconnect = (which == 1); ev_connect = (which == 2);
    step();
    ev_bias = 1'b0; ev_disconnect = 1'b0; ev_connect = 1'b0;
  endtask

  task automatic set_port(input logic d, input logic x, input logic s, input logic ie);
    port_disc = d; port_dis = x; port_susp = s; port_int_en = ie;
  endtask

  task automatic t_reset();
    outs("R1", 1, 5'b11111);
    chk("R1", "if_init in reset", int'(if_init), 0);
    rst_n = 1'b1; step();
    outs("R1", 1, 5'b11111);
    chk("R1", "if_init after reset", int'(if_init), 0);
  endtask

  task automatic t_normal();
    lps = 1'b1; step();
    outs("R2", 0, 5'b11111);
    chk("R9", "if_init on entry", int'(if_init), 1);
    set_port(1'b0, 1'b0, 1'b1, 1'b0); step();
    chk("R9", "if_init second cycle", int'(if_init), 0);
    chk("R3", "normal ignores idle port", int'(pm_state), 0);
    set_port(1'b0, 1'b0, 1'b0, 1'b0);
    lps = 1'b0; step();
    outs("R2", 1, 5'b11111);
    repeat (3) step();
    chk("R3", "active port stays disabled", int'(pm_state), 1);
  endtask

  task automatic t_light_lps();
    set_port(1'b0, 1'b0, 1'b1, 1'b0); step();
    outs("R5", 2, 5'b01100);
    pulse(2);
    lps = 1'b1; step();
    outs("R6", 4, 5'b11110);
    repeat (NT - 1) tick();
    chk("R8", "waking before last tick", int'(pm_state), 4);
    chk("R8", "sysclk_valid before last tick", int'(sysclk_valid), 0);
    tick();
    outs("R8", 0, 5'b11111);
    chk("R9", "if_init after wake", int'(if_init), 1);
    step();
    chk("R9", "if_init drops", int'(if_init), 0);
    lps = 1'b0; step();
  endtask

  task automatic t_depths();
    set_port(1'b1, 1'b0, 1'b0, 1'b0); step();
    outs("R4", 3, 5'b00100);
    chk("R5", "deep sleep det ref off", int'(ref_det_en), 0);
    pulse(0);
    chk("R7", "bias ignored unsuspended", int'(pm_state), 3);
    pulse(1);
    chk("R7", "disconnect ignored unsuspended", int'(pm_state), 3);
    set_port(1'b0, 1'b1, 1'b0, 1'b0); step();
    chk("R4", "disabled no int deep", int'(pm_state), 3);
    pulse(2);
    outs("R7", 3, 5'b00100);
    port_int_en = 1'b1; step();
    outs("R4", 2, 5'b01100);
    port_int_en = 1'b0; step();
    chk("R4", "back to deep", int'(pm_state), 3);
    set_port(1'b1, 1'b0, 1'b0, 1'b0); step();
    pulse(2);
    chk("R7", "connect wakes deep", int'(pm_state), 4);
    repeat (NT) tick();
    outs("R8", 1, 5'b11111);
    chk("R9", "no if_init without lps", int'(if_init), 0);
    step();
    chk("R3", "idle port sleeps again", int'(pm_state), 3);
  endtask

  task automatic t_susp_events();
    set_port(1'b0, 1'b0, 1'b1, 1'b0); step();
    chk("R4", "suspended light", int'(pm_state), 2);
    pulse(0);
    chk("R7", "bias on suspended wakes", int'(pm_state), 4);
    repeat (NT) tick();
    chk("R8", "event wake ends disabled", int'(pm_state), 1);
    step();
    chk("R3", "re-enter light", int'(pm_state), 2);
    pulse(1);
    chk("R7", "disconnect on suspended wakes", int'(pm_state), 4);
    lps = 1'b1;
    repeat (NT) tick();
    chk("R8", "lps during wake ends normal", int'(pm_state), 0);
    chk("R9", "if_init after event wake", int'(if_init), 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_normal();
    t_light_lps();
    t_depths();
    t_susp_events();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule